// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block steers a programmable-logic configuration sequence from a small word-addressed register port. Software programs a control word (enable, active-low chip enable, a held configuration-reset pull, data-path enable, plus ratio and width fields kept for readback). A hardware phase machine then moves through power-up, reset, configuration, initialization and user mode. It reacts to the control word, to a power-good input, to the configuration done and active-low status inputs, and to the expiry of a data-clock countdown.

The mode-select pins are registered and decoded by a lookup. The lookup gives three things: whether the mode is supported, the clock-to-data ratio (1, 2, 4 or 8), and the data width (16 or 32 bits). The data port takes configuration words only while the data-path enable bit is set. It spends one word slot of ratio cycles per word and strobes an accept for each word. In 16-bit mode it zeroes the upper half of the word it presents to the consumer. The consumer itself is outside the block.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset every register reads zero: status (index 0), control (index 1), count (index 2) and count status (index 3). No word is accepted.
- R2: While power_good is low, status bits [2:0] read 0 (power-up), whatever the control word holds. When power_good falls, the phase returns to 0 on the next clock.
- R3: With power_good high, enable (control bit 0) and reset pull (control bit 2) both 1 move the phase to 1 (reset) one clock after the control register updates. The cfg_pull output is the AND of those two bits.
- R4: In reset, with enable 1, reset pull 0 and a supported mode, the phase moves to 2 (configuration) on the next clock.
- R5: A mode-select value with bit 4 set, or with bits [1:0] equal to 3, is unsupported. While the phase is reset and the mode is unsupported, the phase stays 1 and a sticky flag is set at status bit 8. Only reset clears that flag.
- R6: In configuration, done_in and nstatus_in both high move the phase to 3 (initialization). Both low move it to 5 (unknown), where it stays until a reset pull.
- R7: Writing N to index 2 loads a countdown that drops by one per clock. The clock on which it reaches zero sets count status bit 0. That bit stays set until a write to index 3 with bit 0 set clears it.
- R8: In initialization, expiry of the countdown moves the phase to 4 (user mode). Clearing enable afterwards leaves the phase at 4.
- R9: The data port accepts no word while control bit 8 (data-path enable) is 0.
- R10: With data_wr held and the data path enabled, data_accept is high on every Nth cycle: cycles N-1, 2N-1 and so on. The ratio N comes from mode-select bit 3 and bits [1:0]. When bit 3 is 0, values 0, 1, 2 give 1, 2, 4. When bit 3 is 1, values 0, 1, 2 give 1, 4, 8.
- R11: When mode-select bit 3 is 0 (16-bit width), cfg_word carries only the low 16 bits of data_wdata and zeroes the upper half. When it is 1, cfg_word carries the full word.
- R12: Status bits [7:3] show the mode-select pins one clock after they are sampled. Control reads back only bits 0, 1, 2, 6, 7, 8 and 9; every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_good | input | 1 | Supply good; phase is held at power-up while low |
| msel_pins | input | 5 | Mode-select pins |
| done_in | input | 1 | Configuration done from the consumer |
| nstatus_in | input | 1 | Active-low status from the consumer |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index (byte offset divided by four) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx, combinational |
| data_wr | input | 1 | Configuration word offered |
| data_wdata | input | 32 | Configuration word |
| data_accept | output | 1 | Word taken this cycle |
| cfg_word | output | 32 | Word presented to the consumer, width-masked |
| cfg_pull | output | 1 | Configuration reset pull to the consumer |
| chip_en_n | output | 1 | Active-low chip enable to the consumer |
| dclk_active | output | 1 | High while the data-clock countdown is running |

## Verification
Register reads are combinational, so a read returns the state as of the last edge. A control write lands at the edge that follows the write strobe. The phase reacts one edge after that, and a change on done_in, nstatus_in or power_good moves the phase at the very next edge. The bench therefore reads at least one full cycle after each write and reads once before the reaction is due. The countdown result is sampled N edges after the count write, with the done flag still clear one cycle earlier. data_accept is checked every cycle of a held burst against the position N-1 modulo N. Every expected value goes into a queue, and a monitor compares it two nanoseconds after the falling edge, well clear of the rising edge.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        PH_POWERUP = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    // control word fields, packed from high to low
    typedef struct packed {
        logic       width32;
        logic       dpath_en;
        logic [1:0] ratio;
        logic       pull;
        logic       chip_en_n;
        logic       enable;
    } ctrl_t;

    localparam logic [1:0] IDX_STATUS = 2'd0;
    localparam logic [1:0] IDX_CTRL   = 2'd1;
    localparam logic [1:0] IDX_DCOUNT = 2'd2;
    localparam logic [1:0] IDX_DSTAT  = 2'd3;

endpackage

// File: rtl/cfg_mode_lut.sv
module cfg_mode_lut #(
    parameter int RATIO_W = 2
) (
    input  logic [1:0]         rate_sel,
    input  logic               family,
    input  logic               upper_set,
    output logic               mode_ok,
    output logic [RATIO_W-1:0] ratio_log2,
    output logic               width32
);
    always_comb begin
        mode_ok    = !upper_set && (rate_sel != 2'b11);
        width32    = family;
        ratio_log2 = '0;
        if (mode_ok) begin
            case (rate_sel)
                2'd1:    ratio_log2 = family ? RATIO_W'(2) : RATIO_W'(1);
                2'd2:    ratio_log2 = family ? RATIO_W'(3) : RATIO_W'(2);
                default: ratio_log2 = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_dclk_counter.sv
module cfg_dclk_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_done,
    output logic [CNT_W-1:0] remain,
    output logic             done,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } dclk_state_t;

    dclk_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = (s_q.cnt == CNT_W'(1)) && !load;
        if (load) begin
            s_d.cnt = load_val;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
        if (expire) begin
            s_d.done = 1'b1;
        end else if (clr_done) begin
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign remain = s_q.cnt;
    assign done   = s_q.done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !clr_done) |=> s_q.done); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0 && !load) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1))); // R7
endmodule

// File: rtl/cfg_data_port.sv
module cfg_data_port #(
    parameter int DATA_W  = 32,
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_wr,
    input  logic [DATA_W-1:0]  data_wdata,
    input  logic               dpath_en,
    input  logic [RATIO_W-1:0] ratio_log2,
    input  logic               width32,
    output logic               data_accept,
    output logic [DATA_W-1:0]  cfg_word
);
    localparam int SPAN_W = (1 << RATIO_W) - 1;
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [SPAN_W-1:0] cnt;
    } port_state_t;

    port_state_t       s_d, s_q;
    logic [SPAN_W-1:0] limit;
    logic              busy;

    always_comb begin
        limit = '0;
        for (int k = 0; k < SPAN_W; k++) begin
            if (k < int'(ratio_log2)) limit[k] = 1'b1;
        end
    end

    always_comb begin
        s_d         = s_q;
        busy        = data_wr && dpath_en;
        data_accept = busy && (s_q.cnt == limit);
        if (!busy || data_accept) s_d.cnt = '0;
        else                      s_d.cnt = s_q.cnt + SPAN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (HALF_W > 0) begin : g_mask
            always_comb begin
                cfg_word = data_wdata;
                if (!width32) cfg_word[DATA_W-1:HALF_W] = '0;
            end
        end else begin : g_pass
            assign cfg_word = data_wdata;
        end
    endgenerate

    AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (data_accept && ratio_log2 != '0) |=> (!data_accept || ratio_log2 == '0)); // R10
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
    import cfg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   power_good,
    input  logic   enable,
    input  logic   pull,
    input  logic   mode_ok,
    input  logic   done_in,
    input  logic   nstatus_in,
    input  logic   dclk_expire,
    output phase_e phase,
    output logic   bad_mode
);
    typedef struct packed {
        phase_e phase;
        logic   bad_mode;
    } fsm_state_t;

    fsm_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.phase == PH_RESET && !mode_ok) s_d.bad_mode = 1'b1;
        if (!power_good) begin
            s_d.phase = PH_POWERUP;
        end else if (enable && pull) begin
            s_d.phase = PH_RESET;
        end else begin
            case (s_q.phase)
                PH_RESET:  if (enable && mode_ok) s_d.phase = PH_CONFIG;
                PH_CONFIG: begin
                    if (done_in && nstatus_in)        s_d.phase = PH_INIT;
                    else if (!done_in && !nstatus_in) s_d.phase = PH_UNKNOWN;
                end
                PH_INIT:   if (dclk_expire) s_d.phase = PH_USER;
                default:   s_d.phase = s_q.phase;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_POWERUP, bad_mode: 1'b0};
        else        s_q <= s_d;
    end

    assign phase    = s_q.phase;
    assign bad_mode = s_q.bad_mode;

    AST_POWER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> (s_q.phase == PH_POWERUP)); // R2
    AST_PULL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (power_good && enable && pull) |=> (s_q.phase == PH_RESET)); // R3
    AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RESET && !mode_ok) |=> (s_q.phase != PH_CONFIG)); // R5
    AST_BAD_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bad_mode |=> s_q.bad_mode); // R5
    AST_USER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_USER) |=> (s_q.phase != PH_USER || $past(s_q.phase) == PH_INIT)); // R8
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MSEL_W  = 5,
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_good,
    input  logic [MSEL_W-1:0] msel_pins,
    input  logic              done_in,
    input  logic              nstatus_in,
    input  logic              reg_wr,
    input  logic [1:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              data_accept,
    output logic [DATA_W-1:0] cfg_word,
    output logic              cfg_pull,
    output logic              chip_en_n,
    output logic              dclk_active
);
    localparam int CTRL_W = 10;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [MSEL_W-1:0] msel;
    } top_state_t;

    top_state_t         s_d, s_q;
    logic               mode_ok;
    logic [RATIO_W-1:0] ratio_log2;
    logic               width32;
    logic [CNT_W-1:0]   remain;
    logic               dclk_done;
    logic               dclk_expire;
    phase_e             phase;
    logic               bad_mode;
    logic               ctrl_wr;
    logic [CTRL_W-1:0]  ctrl_word;

    always_comb begin
        s_d      = s_q;
        s_d.msel = msel_pins;
        ctrl_wr  = reg_wr && (reg_idx == IDX_CTRL);
        if (ctrl_wr) begin
            s_d.ctrl.enable    = reg_wdata[0];
            s_d.ctrl.chip_en_n = reg_wdata[1];
            s_d.ctrl.pull      = reg_wdata[2];
            s_d.ctrl.ratio     = reg_wdata[7:6];
            s_d.ctrl.dpath_en  = reg_wdata[8];
            s_d.ctrl.width32   = reg_wdata[9];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    cfg_mode_lut #(.RATIO_W(RATIO_W)) u_lut (
        .rate_sel   (s_q.msel[1:0]),
        .family     (s_q.msel[3]),
        .upper_set  (|(s_q.msel >> 4)),
        .mode_ok    (mode_ok),
        .ratio_log2 (ratio_log2),
        .width32    (width32)
    );

    cfg_dclk_counter #(.CNT_W(CNT_W)) u_dclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr && (reg_idx == IDX_DCOUNT)),
        .load_val (CNT_W'(reg_wdata)),
        .clr_done (reg_wr && (reg_idx == IDX_DSTAT) && reg_wdata[0]),
        .remain   (remain),
        .done     (dclk_done),
        .expire   (dclk_expire)
    );

    cfg_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .power_good  (power_good),
        .enable      (s_q.ctrl.enable),
        .pull        (s_q.ctrl.pull),
        .mode_ok     (mode_ok),
        .done_in     (done_in),
        .nstatus_in  (nstatus_in),
        .dclk_expire (dclk_expire),
        .phase       (phase),
        .bad_mode    (bad_mode)
    );

    cfg_data_port #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_wr     (data_wr),
        .data_wdata  (data_wdata),
        .dpath_en    (s_q.ctrl.dpath_en),
        .ratio_log2  (ratio_log2),
        .width32     (width32),
        .data_accept (data_accept),
        .cfg_word    (cfg_word)
    );

    assign ctrl_word = {s_q.ctrl.width32, s_q.ctrl.dpath_en, s_q.ctrl.ratio, 3'b000,
                        s_q.ctrl.pull, s_q.ctrl.chip_en_n, s_q.ctrl.enable};

    always_comb begin
        case (reg_idx)
            IDX_STATUS: reg_rdata = DATA_W'({bad_mode, s_q.msel, phase});
            IDX_CTRL:   reg_rdata = DATA_W'(ctrl_word);
            IDX_DCOUNT: reg_rdata = DATA_W'(remain);
            default:    reg_rdata = DATA_W'(dclk_done);
        endcase
    end

    assign cfg_pull    = s_q.ctrl.enable && s_q.ctrl.pull;
    assign chip_en_n   = s_q.ctrl.chip_en_n;
    assign dclk_active = (remain != '0);

    AST_GATED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[8]) |=> !data_accept); // R9
endmodule

// File: tb/tb_cfg_seq_ctrl.sv
module tb_cfg_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        power_good = 1'b0;
    logic [4:0]  msel_pins = '0;
    logic        done_in = 1'b0;
    logic        nstatus_in = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        data_wr = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        data_accept;
    logic [31:0] cfg_word;
    logic        cfg_pull;
    logic        chip_en_n;
    logic        dclk_active;

    always #4 clk = ~clk;

    cfg_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .power_good(power_good), .msel_pins(msel_pins),
        .done_in(done_in), .nstatus_in(nstatus_in), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_wr(data_wr),
        .data_wdata(data_wdata), .data_accept(data_accept), .cfg_word(cfg_word),
        .cfg_pull(cfg_pull), .chip_en_n(chip_en_n), .dclk_active(dclk_active)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    item_t       it;
    logic [31:0] act;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {31'b0, data_accept};
                2:       act = cfg_word;
                default: act = {31'b0, cfg_pull};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] e, input string tag);
        item_t x;
        x.kind = kind; x.exp = e; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] v);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [31:0] e, input string tag);
        reg_idx = idx;
        push(0, e, tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ratio 0 means the data path is disabled: no accept expected
    task automatic burst(input int n, input int ratio, input logic [31:0] w,
                         input logic [31:0] ew, input string tag);
        data_wr = 1'b1; data_wdata = w;
        for (int i = 0; i < n; i++) begin
            logic hit;
            hit = (ratio != 0) && ((i % ratio) == ratio - 1);
            push(1, {31'b0, hit}, tag);
            if (hit) push(2, ew, tag);
            @(negedge clk);
        end
        data_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 32'h0, "R1 status");
        rd(1, 32'h0, "R1 ctrl");
        rd(2, 32'h0, "R1 count");
        push(1, 32'h0, "R1 accept");
        rd(3, 32'h0, "R1 count status");
        // R2 power-up held without power good
        wr(1, 32'h5);
        idle(2);
        rd(0, 32'h0, "R2 no power");
        push(3, 32'h1, "R3 cfg_pull");
        // R3 reset phase one clock after power good
        power_good = 1'b1;
        rd(0, 32'h0, "R3 not yet");
        rd(0, 32'h1, "R3 reset phase");
        // R5 unsupported mode
        msel_pins = 5'b00011;
        idle(2);
        wr(1, 32'h1);
        idle(2);
        rd(0, 32'h119, "R5 flag and hold");
        // R4 supported mode releases to configuration
        msel_pins = 5'b01010;
        idle(3);
        rd(0, 32'h152, "R4 config phase");
        // R12 control readback
        wr(1, 32'hFFFF_FFFB);
        rd(1, 32'h3C3, "R12 ctrl readback");
        // R10 ratio x8, 32-bit
        burst(16, 8, 32'hA5A5_1234, 32'hA5A5_1234, "R10 x8");
        // R11 ratio x2, 16-bit
        msel_pins = 5'b00001;
        idle(2);
        rd(0, 32'h10A, "R12 msel field");
        burst(6, 2, 32'hA5A5_1234, 32'h0000_1234, "R11 x2 16-bit");
        msel_pins = 5'b00000;
        idle(2);
        burst(4, 1, 32'hDEAD_BEEF, 32'h0000_BEEF, "R10 x1");
        // R9 data path disabled
        wr(1, 32'h0C3);
        burst(4, 0, 32'h1111_2222, 32'h0, "R9 gated");
        rd(0, 32'h102, "R9 phase kept");
        // R6 success
        done_in = 1'b1; nstatus_in = 1'b1;
        idle(1);
        rd(0, 32'h103, "R6 init phase");
        // R7 countdown, R8 user mode
        wr(2, 32'd3);
        rd(2, 32'd3, "R7 count loaded");
        rd(3, 32'h0, "R7 not done 2");
        rd(3, 32'h0, "R7 not done 1");
        rd(3, 32'h1, "R7 done");
        rd(0, 32'h104, "R8 user mode");
        wr(3, 32'h1);
        rd(3, 32'h0, "R7 cleared");
        wr(1, 32'h0);
        idle(1);
        rd(0, 32'h104, "R8 enable cleared");
        // R6 failure path
        done_in = 1'b0; nstatus_in = 1'b1;
        wr(1, 32'h5);
        idle(1);
        rd(0, 32'h101, "R3 back to reset");
        wr(1, 32'h1);
        idle(1);
        rd(0, 32'h102, "R4 config again");
        done_in = 1'b0; nstatus_in = 1'b0;
        idle(1);
        rd(0, 32'h105, "R6 failure");
        // R2 power loss
        power_good = 1'b0;
        idle(1);
        rd(0, 32'h100, "R2 power lost");
        idle(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule